// File: doc/BRIEF.md
# Serial DAC Input Register Controller

This block is the digital front end of a 12-bit segmented voltage-output converter. A host writes a code over three wires: an active-low frame select, a serial clock and a serial data line. While the frame select is low, each rising serial clock edge samples one data bit into a 12-bit shift register, most significant bit first. When the frame select returns high, the shift register is copied into a holding register that drives the converter. A one-cycle update strobe marks each copy.

The held code is offset binary. Code 0 is negative full scale, 2048 is zero output, and 4095 is one step below positive full scale. The top three bits of the held code select how many of seven equal segments are switched in, sent out as a thermometer bus. The lower nine bits drive the binary part of the ladder directly.

The three serial inputs are asynchronous to the block clock. They pass through synchronizers, and edges are detected in the clock domain. Reset presets both registers to midscale. The converter therefore starts at zero volts and stays there until the first complete frame ends.

Top module: `sdac_frontend`

## Requirements
- R1: After reset, code_o is 0x800 (midscale), therm_o is 7'b000_1111, bin_o is 0 and upd_o is 0.
- R2: On each synchronized rising edge of sclk_i while cs_n_i is low, the shift register moves up one place and takes sdi_i into bit 0. Twelve edges therefore deliver a word most significant bit first.
- R3: code_o changes only on a rising edge of cs_n_i. Holding cs_n_i low from reset through a whole frame leaves code_o at midscale until that rise.
- R4: If more than 12 serial clock edges occur in one frame, only the last 12 bits are loaded, and earlier bits are lost.
- R5: If k < 12 edges occur in a frame, the loaded code is the previous shift contents moved up by k places, with the k new bits in the low positions.
- R6: Serial clock edges while cs_n_i is high have no effect on the shift register. A later frame with no clock edges reloads the unchanged contents.
- R7: therm_o has its lowest N lines set, where N is code_o[11:9]. N=0 sets no lines and N=7 sets all seven.
- R8: bin_o equals code_o[8:0].
- R9: Every load raises upd_o for exactly one clock cycle, in the same cycle that code_o takes the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| cs_n_i | input | 1 | Active-low frame select, asynchronous |
| sdi_i | input | 1 | Serial data, sampled on sclk_i rising edges |
| code_o | output | 12 | Held offset-binary code |
| therm_o | output | 7 | Thermometer segment lines from the top three code bits |
| bin_o | output | 9 | Binary ladder bits, the low nine code bits |
| upd_o | output | 1 | One-cycle strobe on each load of code_o |

## Verification
The bench holds the frame select low from reset through a full frame and checks that the output stays at midscale until the select rises. A design that loads on the falling edge, or on a bit count, would instead show the new code early.

Frames of sixteen and of four clocks check the two kinds of misalignment. The longer frame exposes a register that stops after twelve bits. The shorter frame exposes one that clears at the start of a frame.

Serial clock toggles with the select high, followed by a clockless frame, catch a shifter that does not gate on the select. Table vectors at each segment count catch decoders that are off by one line or inverted. The bench also counts the cycles that upd_o is high in each frame, which catches a strobe that is level-held or missing.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Default geometry of the converter front end.
  localparam int DEF_CODE_W   = 12;
  localparam int DEF_SEG_BITS = 3;
  localparam int DEF_SYNC_N   = 2;

  // Edge events extracted from a synchronized input.
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } edge_ev_t;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], din};
    end
  end

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/sdac_edge.sv
module sdac_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lvl_i,
  output sdac_pkg::edge_ev_t ev_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RST_VAL;
    end else begin
      prev_q <= lvl_i;
    end
  end

  always_comb begin
    ev_o.level = lvl_i;
    ev_o.rise  = lvl_i & ~prev_q;
    ev_o.fall  = ~lvl_i & prev_q;
  end

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int CODE_W = sdac_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [CODE_W-1:0] word_o
);

  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  function automatic logic [CODE_W-1:0] push_bit(input logic [CODE_W-1:0] w,
                                                 input logic b);
    return {w[CODE_W-2:0], b};
  endfunction

  logic [CODE_W-1:0] sreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= MID;
    end else if (shift_en) begin
      sreg_q <= push_bit(sreg_q, bit_i);
    end
  end

  assign word_o = sreg_q;

  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sreg_q[0] == $past(bit_i)) &&
                 (sreg_q[CODE_W-1:1] == $past(sreg_q[CODE_W-2:0]))); // R2

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sreg_q)); // R6

endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
  parameter int CODE_W = sdac_pkg::DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] word_i,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o
);

  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] code_q;
  logic              upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= MID;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= load_i;
      if (load_i) begin
        code_q <= word_i;
      end
    end
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;

  AST_LOAD_COPIES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (code_q == $past(word_i)) && upd_q); // R9

  AST_CHANGE_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |-> upd_q); // R3

endmodule

// File: rtl/sdac_segdec.sv
module sdac_segdec #(
  parameter int CODE_W   = sdac_pkg::DEF_CODE_W,
  parameter int SEG_BITS = sdac_pkg::DEF_SEG_BITS
) (
  input  logic [CODE_W-1:0]            code_i,
  output logic [(1<<SEG_BITS)-2:0]     therm_o,
  output logic [CODE_W-SEG_BITS-1:0]   bin_o
);

  localparam int THERM_W = (1 << SEG_BITS) - 1;
  localparam int BIN_W   = CODE_W - SEG_BITS;

  function automatic logic seg_on(input logic [SEG_BITS-1:0] seg, input int line);
    return (int'(seg) > line);
  endfunction

  logic [SEG_BITS-1:0] seg_sel;
  assign seg_sel = code_i[CODE_W-1 -: SEG_BITS];

  for (genvar i = 0; i < THERM_W; i++) begin : g_line
    assign therm_o[i] = seg_on(seg_sel, i);
  end

  assign bin_o = code_i[BIN_W-1:0];

endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend #(
  parameter int CODE_W   = sdac_pkg::DEF_CODE_W,
  parameter int SEG_BITS = sdac_pkg::DEF_SEG_BITS,
  parameter int SYNC_N   = sdac_pkg::DEF_SYNC_N
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sclk_i,
  input  logic                            cs_n_i,
  input  logic                            sdi_i,
  output logic [CODE_W-1:0]               code_o,
  output logic [(1<<SEG_BITS)-2:0]        therm_o,
  output logic [CODE_W-SEG_BITS-1:0]      bin_o,
  output logic                            upd_o
);

  import sdac_pkg::*;

  localparam int THERM_W = (1 << SEG_BITS) - 1;

  // Synchronized levels; idle levels are reset values so that a
  // select held low at power-up is seen only as a fall.
  logic sclk_s, cs_s, sdi_s;

  sdac_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .din(sclk_i), .dout(sclk_s));
  sdac_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .din(cs_n_i), .dout(cs_s));
  sdac_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .din(sdi_i), .dout(sdi_s));

  edge_ev_t sclk_ev, cs_ev;

  sdac_edge #(.RST_VAL(1'b1)) u_edge_sclk (
    .clk(clk), .rst_n(rst_n), .lvl_i(sclk_s), .ev_o(sclk_ev));
  sdac_edge #(.RST_VAL(1'b1)) u_edge_cs (
    .clk(clk), .rst_n(rst_n), .lvl_i(cs_s), .ev_o(cs_ev));

  // Named internal events.
  logic              bit_strobe;
  logic              frame_end;
  logic              frame_open;
  logic              sclk_fall_unused;
  logic              cs_fall_unused;
  logic [CODE_W-1:0] shift_word;

  assign frame_open       = ~cs_ev.level;
  assign bit_strobe       = sclk_ev.rise & frame_open;
  assign frame_end        = cs_ev.rise;
  assign sclk_fall_unused = sclk_ev.fall;
  assign cs_fall_unused   = cs_ev.fall;

  sdac_shift #(.CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(bit_strobe), .bit_i(sdi_s),
    .word_o(shift_word));

  sdac_hold #(.CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(frame_end), .word_i(shift_word),
    .code_o(code_o), .upd_o(upd_o));

  sdac_segdec #(.CODE_W(CODE_W), .SEG_BITS(SEG_BITS)) u_segdec (
    .code_i(code_o), .therm_o(therm_o), .bin_o(bin_o));

  AST_NO_SHIFT_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    cs_ev.level |=> $stable(shift_word)); // R6

  AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o); // R9

  AST_THERM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(therm_o) == int'(code_o[CODE_W-1 -: SEG_BITS])); // R7

  AST_THERM_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_o & (therm_o + THERM_W'(1))) == '0); // R7

  AST_LOAD_NEEDS_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_o) |-> $past(cs_s)); // R3

  AST_BIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    bin_o == code_o[CODE_W-SEG_BITS-1:0]); // R8

  AST_NO_BIT_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> !cs_s && !sclk_fall_unused && !cs_fall_unused); // R2

endmodule

// File: tb/sdac_frontend_bench.sv
module sdac_frontend_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 40;
  localparam int NVEC       = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_i = 1'b0;
  logic        cs_n_i = 1'b1;
  logic        sdi_i = 1'b0;
  logic [11:0] code_o;
  logic [6:0]  therm_o;
  logic [8:0]  bin_o;
  logic        upd_o;

  int errors = 0;
  int checks = 0;
  int upd_cnt = 0;
  bit done = 0;
  logic [11:0] mdl;

  // word, expected thermometer lines, expected binary bits
  localparam logic [11:0] V_WORD [NVEC] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF,
                                           12'h200, 12'hC01, 12'hA5A, 12'h35C};
  localparam logic [6:0]  V_THERM[NVEC] = '{7'h00, 7'h7F, 7'h0F, 7'h07,
                                           7'h01, 7'h3F, 7'h1F, 7'h01};
  localparam logic [8:0]  V_BIN  [NVEC] = '{9'h000, 9'h1FF, 9'h000, 9'h1FF,
                                           9'h000, 9'h001, 9'h05A, 9'h15C};

  sdac_frontend u_sdac_frontend (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .cs_n_i(cs_n_i), .sdi_i(sdi_i),
    .code_o(code_o), .therm_o(therm_o), .bin_o(bin_o), .upd_o(upd_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (upd_o) upd_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Clock n bits of w (MSB of the n-bit field first) with select low.
  task automatic clock_bits(input int n, input logic [31:0] w);
    for (int i = n - 1; i >= 0; i--) begin
      sdi_i = w[i];
      #HALF_SCLK sclk_i = 1'b1;
      #HALF_SCLK sclk_i = 1'b0;
      mdl = {mdl[10:0], w[i]};
    end
  endtask

  task automatic frame(input int n, input logic [31:0] w);
    cs_n_i = 1'b0;
    #HALF_SCLK;
    clock_bits(n, w);
    #HALF_SCLK;
    upd_cnt = 0;
    cs_n_i = 1'b1;
    #(CLK_PERIOD*10);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mdl = 12'h800;
    // Power-up with select held low (R1, R3)
    cs_n_i = 1'b0;
    #(CLK_PERIOD*5);
    rst_n = 1'b1;
    #(CLK_PERIOD*5);
    @(negedge clk);
    chk("R1 code", code_o, 12'h800);
    chk("R1 therm", therm_o, 7'h0F);
    chk("R1 bin", bin_o, 0);
    chk("R1 upd", upd_o, 0);
    #HALF_SCLK;
    clock_bits(12, 32'h5A3);
    #(CLK_PERIOD*10);
    @(negedge clk);
    chk("R3 held before rise", code_o, 12'h800);
    upd_cnt = 0;
    cs_n_i = 1'b1;
    #(CLK_PERIOD*10);
    @(negedge clk);
    chk("R3 load on rise", code_o, 12'h5A3);
    chk("R9 strobe cycles", upd_cnt, 1);

    // Table of vectors, 12-bit frames (R2, R7, R8, R9)
    for (int v = 0; v < NVEC; v++) begin
      frame(12, {20'h0, V_WORD[v]});
      chk("R2 code", code_o, V_WORD[v]);
      chk("R7 therm", therm_o, V_THERM[v]);
      chk("R8 bin", bin_o, V_BIN[v]);
      chk("R9 strobe cycles", upd_cnt, 1);
    end

    // Long frame: only last 12 kept (R4)
    frame(16, 32'hABCD);
    chk("R4 long frame", code_o, 12'hBCD);
    chk("R4 model", code_o, mdl);

    // Short frame: old contents move up (R5)
    frame(4, 32'h5);
    chk("R5 short frame", code_o, 12'hCD5);
    chk("R7 therm short", therm_o, 7'h3F);

    // Clocks with select high are ignored (R6)
    sdi_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #HALF_SCLK sclk_i = 1'b1;
      #HALF_SCLK sclk_i = 1'b0;
    end
    #(CLK_PERIOD*5);
    @(negedge clk);
    chk("R6 no load while idle", code_o, 12'hCD5);
    frame(0, 32'h0);
    chk("R6 reload unchanged", code_o, 12'hCD5);
    chk("R9 empty frame strobe", upd_cnt, 1);

    // Reset again returns midscale (R1)
    rst_n = 1'b0;
    #(CLK_PERIOD*2);
    @(negedge clk);
    chk("R1 reset code", code_o, 12'h800);
    chk("R7 reset therm", therm_o, 7'h0F);
    rst_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule